// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

The mapper sits between a set of peripheral data-request lines and a bank of transfer channels. Each of the 75 request lines has a programmable routing entry, written and read through a plain 32-bit register bus. An entry names one destination channel and has a bit that enables the route. The request lines arrive from other clock domains. Each line passes through two synchronizing flops. Each channel then holds a registered copy of the level of the request that drives it.

The channel engines use that registered level for flow control. It also feeds the pending bit that the status register returns on read-back. When the level of a channel goes from low to high, the mapper emits a one-cycle request-after-stop pulse. When it goes from high to low, the mapper emits a one-cycle end-of-receive pulse. The channel status logic turns these pulses into sticky flags. Status storage and data movement belong to other blocks.

The routing entries live in two address windows. Requests 0 to 63 use the low window and requests 64 to 74 use the high window. The bus rejects a write that enables a route to a channel that does not exist. It reports the rejection with a one-cycle error pulse. When several enabled entries point to the same channel, the lowest-numbered one owns that channel.

Top module: `dreq_chmap`

## Requirements
- R1: After reset, every channel level output and every event pulse output is low, and every routing entry reads as zero.
- R2: A routing entry keeps bits 4:0 as the channel number and bit 7 as the route-enable bit. A read returns those two fields in place, with every other bit zero.
- R3: The entry for request n, where n is below 64, is at byte address 0x100 + 4n.
- R4: The entry for request n, where n is from 64 to 74, is at byte address 0x1100 + 4(n - 64). Reads of any other address, including addresses that are not word-aligned, return zero. Writes to them change nothing.
- R5: A write that sets bit 7 with a channel number equal to or above the channel count is rejected. reg_err is high for exactly the one cycle after that write, and the entry keeps its old value. Any other write to an entry is accepted, including one with bit 7 clear and a large channel number, and does not raise reg_err.
- R6: A request line whose entry has bit 7 clear has no effect on any channel output.
- R7: When a channel's level goes from low to high, chan_req goes high and chan_ras pulses high for exactly that one cycle.
- R8: When a channel's level goes from high to low, chan_req goes low and chan_eor pulses high for exactly that one cycle.
- R9: A change on a request line reaches chan_req and the event pulses on the third rising clock edge after the change, and not earlier.
- R10: A channel follows only the lowest-numbered request whose enabled entry names it. Higher-numbered requests routed to the same channel are ignored. A change of ownership that changes the level produces the matching event pulse one cycle after the entry write.
- R11: reg_rdata is loaded on the clock edge that samples reg_rd and keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_err | output | 1 | One-cycle pulse when a routing write is rejected |
| dreq_in | input | 75 | Asynchronous peripheral request levels |
| chan_req | output | 16 | Registered request level per channel |
| chan_ras | output | 16 | Request-after-stop event pulse per channel |
| chan_eor | output | 16 | End-of-receive event pulse per channel |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle. They also assume that every request line holds each level long enough to pass through the synchronizer. This keeps every change visible as one edge on the channel level. The stimulus uses separate tasks for writes and reads. Each request level it drives is held for at least three cycles. The sweep routes one request at a time with every other entry disabled. This keeps the priority rule out of the way except in the case that checks it on purpose.

// File: rtl/dreq_chmap_pkg.sv
package dreq_chmap_pkg;
  localparam int CH_FIELD_W = 5;
  localparam int EN_BIT     = 7;

  typedef struct packed {
    logic                  en;
    logic [CH_FIELD_W-1:0] ch;
  } route_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int W = 75
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/dreq_route_regs.sv
module dreq_route_regs
  import dreq_chmap_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LO_BASE = 'h100,
  parameter int HI_BASE = 'h1100,
  parameter int LO_CNT  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 err_o,
  output route_t [NUM_REQ-1:0] route_o
);
  localparam int HI_CNT = NUM_REQ - LO_CNT;
  localparam int IW     = $clog2(NUM_REQ + 1);

  route_t [NUM_REQ-1:0] route_q;
  logic [DW-1:0]        rdata_q;
  logic                 err_q;
  logic                 lo_hit, hi_hit, hit;
  logic [IW-1:0]        idx;
  logic                 bad_ch;
  logic                 unused_wbits;

  assign unused_wbits = ^{wdata_i[DW-1:EN_BIT+1], wdata_i[EN_BIT-1:CH_FIELD_W]};

  always_comb begin
    lo_hit = (int'(addr_i) >= LO_BASE) && (int'(addr_i) < LO_BASE + 4*LO_CNT)
             && (addr_i[1:0] == 2'b00);
    hi_hit = (int'(addr_i) >= HI_BASE) && (int'(addr_i) < HI_BASE + 4*HI_CNT)
             && (addr_i[1:0] == 2'b00);
    hit    = lo_hit || hi_hit;
    if (lo_hit) idx = IW'((int'(addr_i) - LO_BASE) / 4);
    else        idx = IW'((int'(addr_i) - HI_BASE) / 4 + LO_CNT);
    bad_ch = wdata_i[EN_BIT] && (int'(wdata_i[CH_FIELD_W-1:0]) >= NUM_CH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REQ; i++) route_q[i] <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_i && hit) begin
        if (bad_ch) err_q <= 1'b1;
        else route_q[idx] <= '{en: wdata_i[EN_BIT], ch: wdata_i[CH_FIELD_W-1:0]};
      end
      if (rd_i) begin
        if (hit) begin
          rdata_q <= '0;
          rdata_q[EN_BIT] <= route_q[idx].en;
          rdata_q[CH_FIELD_W-1:0] <= route_q[idx].ch;
        end else begin
          rdata_q <= '0;
        end
      end
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign route_o = route_q;

  // R5
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(wr_i));

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_rng
      // R5
      route_range_chk: assert property (@(posedge clk) disable iff (rst)
        route_q[i].en |-> (int'(route_q[i].ch) < NUM_CH));
    end
  endgenerate
endmodule

// File: rtl/dreq_chan_track.sv
module dreq_chan_track
  import dreq_chmap_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_REQ-1:0]   req_i,
  input  route_t [NUM_REQ-1:0] route_i,
  output logic [NUM_CH-1:0]    lvl_o,
  output logic [NUM_CH-1:0]    ras_o,
  output logic [NUM_CH-1:0]    eor_o
);
  logic [NUM_CH-1:0] lvl_n, lvl_q, ras_q, eor_q;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      lvl_n[c] = 1'b0;
      for (int r = NUM_REQ - 1; r >= 0; r--) begin
        if (route_i[r].en && (int'(route_i[r].ch) == c)) lvl_n[c] = req_i[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      ras_q <= '0;
      eor_q <= '0;
    end else begin
      lvl_q <= lvl_n;
      ras_q <= lvl_n & ~lvl_q;
      eor_q <= ~lvl_n & lvl_q;
    end
  end

  assign lvl_o = lvl_q;
  assign ras_o = ras_q;
  assign eor_o = eor_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R7
      ras_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ras_q[c] |-> (lvl_q[c] && !$past(lvl_q[c])));
      // R8
      eor_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        eor_q[c] |-> (!lvl_q[c] && $past(lvl_q[c])));
      // R7
      level_move_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q[c] != $past(lvl_q[c])) |-> (ras_q[c] || eor_q[c]));
    end
  endgenerate
endmodule

// File: rtl/dreq_chmap.sv
module dreq_chmap
  import dreq_chmap_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int AW      = 16,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               reg_err,
  input  logic [NUM_REQ-1:0] dreq_in,
  output logic [NUM_CH-1:0]  chan_req,
  output logic [NUM_CH-1:0]  chan_ras,
  output logic [NUM_CH-1:0]  chan_eor
);
  logic [NUM_REQ-1:0]   req_s;
  route_t [NUM_REQ-1:0] route;

  dreq_sync #(.W(NUM_REQ)) u_sync (
    .clk(clk), .rst(rst), .async_i(dreq_in), .sync_o(req_s)
  );

  dreq_route_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .err_o(reg_err), .route_o(route)
  );

  dreq_chan_track #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_track (
    .clk(clk), .rst(rst), .req_i(req_s), .route_i(route),
    .lvl_o(chan_req), .ras_o(chan_ras), .eor_o(chan_eor)
  );

  // R11
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
  // R7
  ras_eor_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_ras & chan_eor) == '0);
endmodule

// File: tb/dreq_chmap_test.sv
module dreq_chmap_test;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]      reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             reg_err;
  logic [NREQ-1:0]  dreq_in = '0;
  logic [NCH-1:0]   chan_req, chan_ras, chan_eor;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic last_err;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dreq_chmap uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .dreq_in(dreq_in), .chan_req(chan_req), .chan_ras(chan_ras), .chan_eor(chan_eor)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    last_err = reg_err;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [15:0] addr_of(input int n);
    if (n < 64) return 16'(32'h100 + 4*n);
    return 16'(32'h1100 + 4*(n - 64));
  endfunction

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 chan_req", 64'(chan_req), 64'h0);
    check("R1 chan_ras", 64'(chan_ras), 64'h0);
    check("R1 chan_eor", 64'(chan_eor), 64'h0);
    rd(addr_of(0), rv);  check("R1 entry0", 64'(rv), 64'h0);
    rd(addr_of(74), rv); check("R1 entry74", 64'(rv), 64'h0);

    // Sweep: route each request alone, pulse it, unroute it
    for (int i = 0; i < NREQ; i++) begin
      int ch;
      logic [NCH-1:0] m;
      ch = i % NCH;
      m = NCH'(1) << ch;
      wr(addr_of(i), 32'h80 | 32'(ch));
      rd(addr_of(i), rv);
      if (i < 64) check("R3 R2 readback low", 64'(rv), 64'(32'h80 | 32'(ch)));
      else        check("R4 R2 readback high", 64'(rv), 64'(32'h80 | 32'(ch)));
      dreq_in[i] = 1'b1;
      tick(2);
      check("R9 not yet", 64'(chan_req), 64'h0);
      tick(1);
      check("R7 level up", 64'(chan_req), 64'(m));
      check("R7 ras pulse", 64'(chan_ras), 64'(m));
      tick(1);
      check("R7 ras one cycle", 64'(chan_ras), 64'h0);
      dreq_in[i] = 1'b0;
      tick(3);
      check("R8 level down", 64'(chan_req), 64'h0);
      check("R8 eor pulse", 64'(chan_eor), 64'(m));
      tick(1);
      check("R8 eor one cycle", 64'(chan_eor), 64'h0);
      wr(addr_of(i), 32'h0);
    end

    // R6 unrouted requests do nothing
    dreq_in = '1;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      check("R6 req stays low", 64'(chan_req), 64'h0);
      check("R6 no ras", 64'(chan_ras), 64'h0);
    end
    dreq_in = '0;
    tick(4);

    // R10 priority: requests 3 and 5 both on channel 2
    wr(addr_of(3), 32'h82);
    wr(addr_of(5), 32'h82);
    dreq_in[5] = 1'b1;
    tick(4);
    check("R10 higher ignored", 64'(chan_req), 64'h0);
    dreq_in[3] = 1'b1;
    tick(3);
    check("R10 owner rises", 64'(chan_req), 64'h4);
    check("R10 owner ras", 64'(chan_ras), 64'h4);
    dreq_in[3] = 1'b0;
    tick(3);
    check("R10 owner falls", 64'(chan_req), 64'h0);
    check("R10 owner eor", 64'(chan_eor), 64'h4);
    wr(addr_of(3), 32'h0);
    tick(1);
    check("R10 new owner level", 64'(chan_req), 64'h4);
    check("R10 new owner ras", 64'(chan_ras), 64'h4);
    dreq_in[5] = 1'b0;
    tick(4);
    wr(addr_of(5), 32'h0);

    // R5 rejected write
    wr(addr_of(0), 32'h80 | 32'(NCH));
    check("R5 err pulse", 64'(last_err), 64'h1);
    tick(1);
    check("R5 err one cycle", 64'(reg_err), 64'h0);
    rd(addr_of(0), rv); check("R5 entry kept", 64'(rv), 64'h0);
    wr(addr_of(0), 32'h1F);
    check("R5 no err when disabled", 64'(last_err), 64'h0);
    rd(addr_of(0), rv); check("R5 disabled accepted", 64'(rv), 64'h1F);
    wr(addr_of(70), 32'h80 | 32'(NCH - 1));
    check("R5 top channel ok", 64'(last_err), 64'h0);
    rd(addr_of(70), rv); check("R5 top channel stored", 64'(rv), 64'(32'h80 | 32'(NCH - 1)));

    // R2 other bits read zero
    wr(addr_of(1), 32'hFFFF_FF61);
    rd(addr_of(1), rv); check("R2 spare bits zero", 64'(rv), 64'h01);

    // R4 holes and misaligned
    wr(16'h112C, 32'h81);
    rd(16'h112C, rv); check("R4 past high window", 64'(rv), 64'h0);
    wr(16'h0FC, 32'h81);
    rd(16'h0FC, rv);  check("R4 below low window", 64'(rv), 64'h0);
    wr(16'h102, 32'h85);
    rd(16'h102, rv);  check("R4 misaligned read", 64'(rv), 64'h0);
    rd(addr_of(0), rv); check("R4 misaligned write ignored", 64'(rv), 64'h1F);

    // R11 read data holds
    rd(addr_of(70), rv);
    tick(3);
    check("R11 rdata holds", 64'(reg_rdata), 64'(32'h80 | 32'(NCH - 1)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule